// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block decides, cycle by cycle, when the gate of a synchronous rectifier switch is on. Comparators outside the block report conduction starting, conduction ending and a sense reset as digital flags. The sequencer turns these flags into a single gate-enable output. It also applies timing guards that keep parasitic ringing from flipping the switch.

Every guard is a tick count. There is a start-up delay after the supply comes good. There is a blanking window after turn-on during which an end flag has no effect, and a dead window after turn-off during which a start flag has no effect. There is a ceiling on the length of one pulse. A fast trigger input drops the gate in the same cycle it goes high. If the trigger stays high long enough, the block latches into a disabled state. All tick counts are captured while reset is asserted and hold until the next reset.

Top module: `sr_gate_seq`

## Requirements
- R1: During reset and after it, `gate_on` and `disabled` are low. A start flag has no effect until `supply_ok` has been high at `start_ticks` consecutive rising edges. At the edge after that, a start flag is accepted.
- R2: A low `supply_ok` at a clock edge forces `gate_on` low from the next cycle. The start-up delay of R1 then restarts from zero.
- R3: In the waiting state with the dead window elapsed, a high `cond_start` at an edge makes `gate_on` high from that edge.
- R4: Count the first cycle with the gate high as 1. A `cond_end` seen in high cycle k is ignored when k <= `ton_ticks`. When k > `ton_ticks`, it turns the gate off at the end of cycle k.
- R5: Count the first cycle with the gate low after turn-off as 1. A `cond_start` seen in low cycle k is ignored when k <= `toff_ticks`. When k > `toff_ticks`, it turns the gate on at the end of cycle k.
- R6: A high `sense_rst` at an edge while the gate is off restarts the dead window. While the gate is on, `sense_rst` acts as an end flag under the blanking of R4.
- R7: The gate stays high for at most `pulse_max_ticks` consecutive cycles and is then forced low.
- R8: A high `trig` holds `gate_on` low in the same cycle, even inside the blanking window. Each edge that samples `trig` high restarts the dead window, and no start is accepted while it stays high.
- R9: When `trig` is high at `trig_hold_ticks` consecutive edges, `disabled` goes high in the next cycle. One fewer high edge leaves `disabled` low.
- R10: While `disabled` is high, `gate_on` stays low whatever the flags do. The first edge that samples `trig` low clears `disabled` in the next cycle and restarts the dead window.
- R11: The tick-count inputs are captured only while `rst_n` is low. Changing them after reset has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; tick counts are captured while it is low |
| start_ticks | input | TW | Start-up delay in cycles |
| ton_ticks | input | TW | Turn-on blanking length |
| toff_ticks | input | TW | Turn-off dead window length |
| pulse_max_ticks | input | TW | Longest allowed gate pulse |
| trig_hold_ticks | input | GW | Consecutive high trigger edges that latch disable |
| supply_ok | input | 1 | Supply above its undervoltage threshold |
| cond_start | input | 1 | Conduction has begun |
| cond_end | input | 1 | Conduction has ended |
| sense_rst | input | 1 | Sense circuit reset indication |
| trig | input | 1 | Fast turn-off / disable request |
| gate_on | output | 1 | Gate enable for the rectifier switch |
| disabled | output | 1 | Latched disable state |

## Verification
The bench hits each window exactly at its last ignored cycle and its first accepted cycle. An off-by-one in the blanking, the dead window or the pulse ceiling therefore moves a gate edge by one cycle and is caught. It pulses the trigger inside blanking, where a design that let blanking win would keep the gate high. It holds the trigger for one edge short of the disable count, where a counter that starts at the wrong value would latch early. It changes the tick inputs right after reset, which exposes any design that reads them live instead of capturing them. A sense reset in the middle of the dead window checks that the window restarts, which would otherwise turn the gate on six cycles early.

// File: rtl/sr_gate_seq.sv
module sr_gate_seq #(
  parameter int TW = 24,
  parameter int GW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] start_ticks,
  input  logic [TW-1:0] ton_ticks,
  input  logic [TW-1:0] toff_ticks,
  input  logic [TW-1:0] pulse_max_ticks,
  input  logic [GW-1:0] trig_hold_ticks,
  input  logic          supply_ok,
  input  logic          cond_start,
  input  logic          cond_end,
  input  logic          sense_rst,
  input  logic          trig,
  output logic          gate_on,
  output logic          disabled
);

  localparam logic [TW-1:0] TMAX = '1;
  localparam logic [GW-1:0] GMAX = '1;

  typedef enum logic [1:0] {ST_PWR, ST_WAIT, ST_ON, ST_DIS} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [TW-1:0] c_start, c_ton, c_toff, c_max;
  logic [GW-1:0] c_hold, tcnt;

  wire [TW-1:0] tmr_inc   = (tmr == TMAX) ? tmr : tmr + 1'b1;
  wire [TW:0]   tmr_next  = {1'b0, tmr} + 1'b1;
  wire          up_done   = tmr_next >= {1'b0, c_start};
  wire          toff_done = tmr >= c_toff;
  wire          ton_done  = tmr >= c_ton;
  wire          cap_hit   = tmr_next >= {1'b0, c_max};
  wire          hold_hit  = trig && (({1'b0, tcnt} + 1'b1) >= {1'b0, c_hold});
  wire          end_ok    = (cond_end || sense_rst) && ton_done;

  assign gate_on  = (st == ST_ON) && !trig;
  assign disabled = (st == ST_DIS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_start <= start_ticks;
      c_ton   <= ton_ticks;
      c_toff  <= toff_ticks;
      c_max   <= pulse_max_ticks;
      c_hold  <= trig_hold_ticks;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !trig) tcnt <= '0;
    else if (tcnt != GMAX) tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !supply_ok) begin
      st  <= ST_PWR;
      tmr <= '0;
    end else begin
      case (st)
        ST_PWR: begin
          if (up_done) begin
            st  <= ST_WAIT;
            tmr <= c_toff;
          end else begin
            tmr <= tmr_inc;
          end
        end
        ST_WAIT: begin
          if (hold_hit) begin
            st  <= ST_DIS;
            tmr <= '0;
          end else if (trig || sense_rst) begin
            tmr <= '0;
          end else if (cond_start && toff_done) begin
            st  <= ST_ON;
            tmr <= '0;
          end else begin
            tmr <= tmr_inc;
          end
        end
        ST_ON: begin
          if (hold_hit) begin
            st  <= ST_DIS;
            tmr <= '0;
          end else if (trig || cap_hit || end_ok) begin
            st  <= ST_WAIT;
            tmr <= '0;
          end else begin
            tmr <= tmr_inc;
          end
        end
        default: begin
          if (!trig) begin
            st  <= ST_WAIT;
            tmr <= '0;
          end
        end
      endcase
    end
  end

endmodule

module sr_gate_seq_chk #(
  parameter int TW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          supply_ok,
  input logic          trig,
  input logic          gate_on,
  input logic          disabled,
  input logic [TW-1:0] cfg_ton,
  input logic [TW-1:0] cfg_max
);

  logic [TW-1:0] hi_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !gate_on) hi_run <= '0;
    else hi_run <= hi_run + 1'b1;
  end

  AST_RISE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> $past(supply_ok)); // R1
  AST_SUPPLY_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !gate_on); // R2
  AST_BLANKING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_on) && !trig && $past(supply_ok)) |-> (hi_run > cfg_ton || hi_run == cfg_max)); // R4
  AST_PULSE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> hi_run < cfg_max); // R7
  AST_TRIG_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !gate_on); // R8
  AST_DIS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disabled) |-> $past(trig)); // R9
  AST_DIS_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    disabled |-> !gate_on); // R10

endmodule

bind sr_gate_seq sr_gate_seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .trig(trig),
  .gate_on(gate_on), .disabled(disabled), .cfg_ton(c_ton), .cfg_max(c_max)
);

// File: tb/sr_gate_seq_bench.sv
`timescale 1ns/1ps
module sr_gate_seq_bench;
  localparam int TW = 24;
  localparam int GW = 16;

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] start_ticks, ton_ticks, toff_ticks, pulse_max_ticks;
  logic [GW-1:0] trig_hold_ticks;
  logic supply_ok = 0, cond_start = 0, cond_end = 0, sense_rst = 0, trig = 0;
  logic gate_on, disabled;

  always #4 clk = ~clk;

  sr_gate_seq #(.TW(TW), .GW(GW)) u_sr_gate_seq (
    .clk(clk), .rst_n(rst_n), .start_ticks(start_ticks), .ton_ticks(ton_ticks),
    .toff_ticks(toff_ticks), .pulse_max_ticks(pulse_max_ticks),
    .trig_hold_ticks(trig_hold_ticks), .supply_ok(supply_ok),
    .cond_start(cond_start), .cond_end(cond_end), .sense_rst(sense_rst),
    .trig(trig), .gate_on(gate_on), .disabled(disabled)
  );

  typedef struct { int cyc; bit g; bit d; string tag; } exp_t;
  exp_t q[$];
  int cyc = 0, n_run = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int dt, bit g, bit d, string tag);
    exp_t e;
    e.cyc = cyc + dt; e.g = g; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial forever begin
    @(posedge clk); #6;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc <= cyc) begin
        n_run++;
        if (q[i].cyc < cyc || gate_on !== q[i].g || disabled !== q[i].d) begin
          n_fail++;
          $display("FAIL %s cycle %0d: gate_on=%0b disabled=%0b expected gate_on=%0b disabled=%0b",
                   q[i].tag, q[i].cyc, gate_on, disabled, q[i].g, q[i].d);
        end
        q.delete(i);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    start_ticks = 5; ton_ticks = 4; toff_ticks = 6; pulse_max_ticks = 20; trig_hold_ticks = 8;
    step(3);
    expect_at(0, 0, 0, "R1 reset");
    step(2);
    rst_n = 1;
    // R11: new values after reset must not matter
    start_ticks = 1; ton_ticks = 1; toff_ticks = 1; pulse_max_ticks = 3; trig_hold_ticks = 2;
    expect_at(0, 0, 0, "R1");
    step(2);

    // R1 / R3 start-up then first turn-on
    supply_ok = 1; cond_start = 1;
    expect_at(0, 0, 0, "R1"); expect_at(5, 0, 0, "R1 R11"); expect_at(6, 1, 0, "R3");
    step(6);
    // R4 blanking
    cond_start = 0; cond_end = 1;
    expect_at(4, 1, 0, "R4 R11"); expect_at(5, 0, 0, "R4");
    step(5);
    // R5 dead window
    cond_end = 0; cond_start = 1;
    expect_at(6, 0, 0, "R5 R11"); expect_at(7, 1, 0, "R5");
    step(7);
    // R7 pulse ceiling
    cond_start = 0;
    expect_at(19, 1, 0, "R7 R11"); expect_at(20, 0, 0, "R7");
    step(20);
    // R6 sense reset while off
    expect_at(7, 0, 0, "R6"); expect_at(12, 0, 0, "R6"); expect_at(13, 1, 0, "R6");
    step(5);
    sense_rst = 1; cond_start = 1;
    step(1);
    sense_rst = 0;
    step(7);
    // R6 sense reset while on
    cond_start = 0; sense_rst = 1;
    expect_at(4, 1, 0, "R6"); expect_at(5, 0, 0, "R6");
    step(5);
    sense_rst = 0;
    // R8 trigger inside blanking
    cond_start = 1;
    expect_at(7, 1, 0, "R8 setup");
    step(7);
    cond_start = 0;
    step(1);
    trig = 1;
    expect_at(0, 0, 0, "R8");
    step(1);
    trig = 0; cond_start = 1;
    expect_at(0, 0, 0, "R8"); expect_at(6, 0, 0, "R8"); expect_at(7, 1, 0, "R8");
    step(7);
    cond_start = 0; cond_end = 1;
    expect_at(5, 0, 0, "R4");
    step(5);
    cond_end = 0;
    // R8 start blocked while trigger high
    step(6);
    trig = 1; cond_start = 1;
    for (int k = 0; k < 4; k++) expect_at(k, 0, 0, "R8");
    step(3);
    trig = 0;
    expect_at(6, 0, 0, "R8"); expect_at(7, 1, 0, "R8");
    step(7);
    cond_start = 0; cond_end = 1;
    expect_at(5, 0, 0, "R4");
    step(5);
    cond_end = 0;
    // R9 one edge short of disable
    trig = 1;
    for (int k = 1; k <= 8; k++) expect_at(k, 0, 0, "R9");
    step(7);
    trig = 0;
    step(1);
    // R9 disable entry
    trig = 1;
    expect_at(7, 0, 0, "R9"); expect_at(8, 0, 1, "R9");
    step(8);
    // R10 flags ignored while disabled, then exit
    cond_start = 1; cond_end = 1; sense_rst = 1;
    for (int k = 0; k < 4; k++) expect_at(k, 0, 1, "R10");
    step(4);
    cond_end = 0; sense_rst = 0; trig = 0;
    expect_at(0, 0, 1, "R10"); expect_at(1, 0, 0, "R10");
    expect_at(7, 0, 0, "R10"); expect_at(8, 1, 0, "R10");
    step(8);
    // R2 supply loss during a pulse
    supply_ok = 0;
    expect_at(0, 1, 0, "R2"); expect_at(1, 0, 0, "R2");
    step(2);
    supply_ok = 1;
    expect_at(5, 0, 0, "R2"); expect_at(6, 1, 0, "R2");
    step(6);
    cond_start = 0; cond_end = 1;
    expect_at(5, 0, 0, "R4");
    step(5);
    cond_end = 0;
    step(3);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL pending: %0d expectations unchecked, expected 0", q.size());
    end
    finish_run();
  end
endmodule